// File: doc/BRIEF.md
# Prescaled Timer and Event Counter

This block is the 4-bit timer/counter of a small 4-bit microcontroller core. One count register can be advanced from either of two sources. In timer mode a free-running prescaler advances it once every 64 instruction cycles, which is 256 input clocks when each instruction cycle takes four clocks. In event mode each low-to-high transition on an external event line advances it instead. The core can write a new count at any time through a load strobe.

When the count rolls over from its maximum back to zero, the block can raise a timer interrupt request. A timer flag gates this. The overflow that raises a request also sets the flag in the same clock edge, so no further request is raised until software clears the flag. Reset leaves the flag set, which means no request can be raised until software clears it. The request stays high until the interrupt controller acknowledges it.

A halt input stops the internal time base. The prescaler keeps its partial progress and continues from the same point when the halt is removed.

Top module: `tmr_evt_counter`

## Requirements
- R1: After reset the count is 0, the timer flag is 1, the request is 0, and the prescaler restarts from zero. In timer mode the first increment therefore lands on the TICK-th clock edge after reset is released, where TICK = CYC_CLKS*PRESCALE.
- R2: With modeCount = 0 (timer mode) and no halt, the count increments exactly once every TICK clocks. With the default parameters TICK is 256. Edges on evtLine have no effect in this mode.
- R3: With modeCount = 1 (event mode), the count increments on the clock edge that first sees evtLine high after it was low. A held high level or a falling edge does not increment it, and prescaler overflows do not increment it.
- R4: The count is CNT_W bits wide (default 4). An increment from 2^CNT_W-1 wraps it to 0.
- R5: If a wrap happens while the timer flag is 0, timerReq and timerFlag both become 1 at that same clock edge.
- R6: If a wrap happens while the timer flag is 1, no new request is raised.
- R7: While halt = 1 the prescaler holds its value and timer mode does not increment. After the halt is released, the next increment comes after only the clocks that were still remaining.
- R8: When loadEn = 1 the count takes loadVal at the next edge. The load wins over an increment in the same cycle, and a load can never cause a wrap.
- R9: flagSet = 1 sets the timer flag and flagClr = 1 clears it. When flagClr falls in the same cycle as a wrap that raises a request, the flag ends at 1.
- R10: timerReq stays high until irqAck = 1. If an acknowledge falls in the same cycle as a new raise, the request stays high. The acknowledge never changes the count or the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeCount | input | 1 | 0 = timer mode, 1 = event-count mode |
| evtLine | input | 1 | External event line; rising transitions count in event mode |
| halt | input | 1 | Stops the prescaler while high |
| loadEn | input | 1 | Load strobe for the count |
| loadVal | input | CNT_W | Value written by the load strobe |
| flagSet | input | 1 | Sets the timer flag |
| flagClr | input | 1 | Clears the timer flag |
| irqAck | input | 1 | Acknowledge from the interrupt controller; clears the request |
| count | output | CNT_W | Current count |
| timerFlag | output | 1 | Timer flag; a 1 blocks new requests |
| timerReq | output | 1 | Timer interrupt request, held until acknowledged |

## Verification
Two pairs of functions can land in the same cycle, and the bench forces each pair together.

- **Load and increment.** The bench steps a reduced configuration (TICK = 8) until its own prescaler phase is on the last clock before an overflow, then asserts loadEn on that clock. The loaded value is expected, not the incremented one.
- **Raise and acknowledge.** In event mode the bench loads the maximum count, clears the flag, and drives the rising event edge on the same clock as irqAck, with a request already pending. It then checks that the request stays high.

The same sweep places flagClr on the wrapping edge and expects the flag to end at 1. Every clock is compared against an arithmetic model of count, flag and request.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;

  // Per-cycle strobes issued by the control half to the datapath half.
  typedef struct packed {
    logic inc;      // advance the count this cycle
    logic load;     // write loadVal into the count (wins over inc)
    logic setFlag;  // software set of the timer flag
    logic clrFlag;  // software clear of the timer flag
    logic ack;      // interrupt controller acknowledge
  } tcStrobe_t;

endpackage

// File: rtl/tmr_evt_ctrl.sv
module tmr_evt_ctrl
  import tmr_evt_pkg::*;
#(
  parameter int CYC_CLKS = 4,
  parameter int PRESCALE = 64
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      modeCount,
  input  logic      evtLine,
  input  logic      halt,
  input  logic      loadEn,
  input  logic      flagSet,
  input  logic      flagClr,
  input  logic      irqAck,
  output tcStrobe_t strobes
);

  localparam int TICK  = CYC_CLKS * PRESCALE;
  localparam int PSC_W = (TICK > 1) ? $clog2(TICK) : 1;
  localparam logic [PSC_W-1:0] PSC_LAST = PSC_W'(TICK - 1);

  logic [PSC_W-1:0] psc;
  logic             evtPrev;
  logic             pscTick;
  logic             evtRise;

  // Prescaler: overflows every TICK clocks, frozen while halted.
  assign pscTick = !halt && (psc == PSC_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psc <= '0;
    end else if (!halt) begin
      if (psc == PSC_LAST) psc <= '0;
      else                 psc <= psc + 1'b1;
    end
  end

  // Rising-edge detection on the event line.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evtPrev <= 1'b0;
    else       evtPrev <= evtLine;
  end

  assign evtRise = evtLine && !evtPrev;

  // Source selection and strobe packing.
  always_comb begin
    strobes.inc     = modeCount ? evtRise : pscTick;
    strobes.load    = loadEn;
    strobes.setFlag = flagSet;
    strobes.clrFlag = flagClr;
    strobes.ack     = irqAck;
  end

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    halt |=> psc == $past(psc)); // R7

  AST_PSC_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    pscTick |=> psc == '0); // R2

  AST_LEVEL_NO_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (modeCount && evtPrev) |-> !strobes.inc); // R3

  AST_TIMER_HALT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!modeCount && halt) |-> !strobes.inc); // R7

endmodule

// File: rtl/tmr_evt_data.sv
module tmr_evt_data
  import tmr_evt_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  tcStrobe_t        strobes,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] count,
  output logic             timerFlag,
  output logic             timerReq
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic wrap;
  logic raise;

  assign wrap  = strobes.inc && !strobes.load && (count == CNT_MAX);
  assign raise = wrap && !timerFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             count <= '0;
    else if (strobes.load) count <= loadVal;
    else if (strobes.inc)  count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             timerFlag <= 1'b1;
    else if (strobes.setFlag || raise)     timerFlag <= 1'b1;
    else if (strobes.clrFlag)              timerFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            timerReq <= 1'b0;
    else if (raise)       timerReq <= 1'b1;
    else if (strobes.ack) timerReq <= 1'b0;
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> count == $past(loadVal)); // R8

  AST_REQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timerReq) |-> timerFlag); // R5

  AST_BLOCKED_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (timerFlag && !timerReq) |=> !timerReq || $past(strobes.clrFlag) || !$past(timerFlag)); // R6

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (timerReq && !strobes.ack) |=> timerReq); // R10

  AST_ACK_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ack && !strobes.setFlag && !strobes.clrFlag && !strobes.inc && !strobes.load)
      |=> $stable(timerFlag) && $stable(count)); // R10

endmodule

// File: rtl/tmr_evt_counter.sv
module tmr_evt_counter
  import tmr_evt_pkg::*;
#(
  parameter int CYC_CLKS = 4,
  parameter int PRESCALE = 64,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeCount,
  input  logic             evtLine,
  input  logic             halt,
  input  logic             loadEn,
  input  logic [CNT_W-1:0] loadVal,
  input  logic             flagSet,
  input  logic             flagClr,
  input  logic             irqAck,
  output logic [CNT_W-1:0] count,
  output logic             timerFlag,
  output logic             timerReq
);

  tcStrobe_t strobes;

  tmr_evt_ctrl #(
    .CYC_CLKS(CYC_CLKS),
    .PRESCALE(PRESCALE)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .modeCount (modeCount),
    .evtLine   (evtLine),
    .halt      (halt),
    .loadEn    (loadEn),
    .flagSet   (flagSet),
    .flagClr   (flagClr),
    .irqAck    (irqAck),
    .strobes   (strobes)
  );

  tmr_evt_data #(
    .CNT_W(CNT_W)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .loadVal   (loadVal),
    .count     (count),
    .timerFlag (timerFlag),
    .timerReq  (timerReq)
  );

  AST_RESET_FLAG: assert property (@(posedge clk)
    $rose(rstN) |-> timerFlag && !timerReq && count == '0); // R1

endmodule

// File: tb/tmr_evt_counter_bench.sv
`timescale 1ns/1ps
module tmr_evt_counter_bench;

  localparam int CYC  = 2;
  localparam int PRE  = 4;
  localparam int TICK = CYC * PRE;
  localparam int CW   = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeCount = 1'b0, evtLine = 1'b0, halt = 1'b0;
  logic loadEn = 1'b0, flagSet = 1'b0, flagClr = 1'b0, irqAck = 1'b0;
  logic [CW-1:0] loadVal = '0;
  logic [CW-1:0] count;
  logic timerFlag, timerReq;

  int total = 0;
  int bad = 0;

  // Bench-side expectation state.
  int  phase = 0;
  int  expCount = 0;
  bit  expFlag = 1'b1;
  bit  expReq = 1'b0;
  bit  prevEvt = 1'b0;

  always #4 clk = ~clk;

  tmr_evt_counter #(.CYC_CLKS(CYC), .PRESCALE(PRE), .CNT_W(CW)) u_tmr_evt_counter (
    .clk(clk), .rstN(rstN), .modeCount(modeCount), .evtLine(evtLine), .halt(halt),
    .loadEn(loadEn), .loadVal(loadVal), .flagSet(flagSet), .flagClr(flagClr),
    .irqAck(irqAck), .count(count), .timerFlag(timerFlag), .timerReq(timerReq)
  );

  task automatic check(input string tag);
    total++;
    if (count !== CW'(expCount) || timerFlag !== expFlag || timerReq !== expReq) begin
      bad++;
      $display("FAIL %s: got count=%0d flag=%0b req=%0b exp count=%0d flag=%0b req=%0b",
               tag, count, timerFlag, timerReq, expCount, expFlag, expReq);
    end
  endtask

  // One clock: predict from the requirements, clock, then compare.
  task automatic step(input string tag);
    bit tickNow, rise, inc, wrapNow, raiseNow;
    tickNow = !halt && (phase == TICK - 1);
    rise    = evtLine && !prevEvt;
    inc     = modeCount ? rise : tickNow;
    wrapNow = inc && !loadEn && (expCount == CMAX);
    raiseNow = wrapNow && !expFlag;
    if (!halt) phase = (phase + 1) % TICK;
    prevEvt = evtLine;
    if (loadEn)   expCount = int'(loadVal);
    else if (inc) expCount = (expCount + 1) % (CMAX + 1);
    expFlag = flagSet || raiseNow || (expFlag && !flagClr);
    expReq  = raiseNow || (expReq && !irqAck);
    @(posedge clk);
    #1;
    check(tag);
    loadEn = 1'b0; flagSet = 1'b0; flagClr = 1'b0; irqAck = 1'b0;
  endtask

  initial begin
    #1600000;
    bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset values");
    rstN = 1'b1;

    // R1/R2: first tick lands after TICK clocks; then steady timer sweep,
    // including wrap with flag set (R4, R6) and evt toggles ignored.
    for (int i = 0; i < TICK * 18; i++) begin
      evtLine = i[1];
      step("R1 R2 R4 R6 timer sweep");
    end
    evtLine = 1'b0;

    // R9 clear flag, then R5 raise on wrap, R10 hold and ack.
    flagClr = 1'b1;
    step("R9 flag clear");
    for (int i = 0; i < TICK * 17; i++) step("R5 R10 raise and hold");
    irqAck = 1'b1;
    step("R10 ack clears request");

    // R7 halt mid-prescale.
    for (int i = 0; i < 3; i++) step("R7 pre-halt");
    halt = 1'b1;
    for (int i = 0; i < 25; i++) step("R7 halted");
    halt = 1'b0;
    for (int i = 0; i < TICK * 2; i++) step("R7 resume");

    // R8 load on the same cycle as a prescaler overflow.
    for (int n = 0; n < 4; n++) begin
      while (phase != TICK - 1) step("R8 align");
      loadEn = 1'b1; loadVal = CW'(9 + n);
      step("R8 load beats tick");
    end
    // Load of max with tick present: no wrap.
    flagClr = 1'b1;
    step("R9 clear");
    while (phase != TICK - 1) step("R8 align");
    loadEn = 1'b1; loadVal = CW'(CMAX);
    step("R8 load max no wrap");

    // R3 event mode sweep with varied patterns.
    modeCount = 1'b1;
    for (int p = 0; p < 4; p++) begin
      for (int b = 0; b < 16; b++) begin
        evtLine = (16'h6E2B >> ((b + 5 * p) % 16)) & 1'b1;
        step("R3 event sweep");
      end
    end
    evtLine = 1'b0;
    step("R3 settle");
    for (int i = 0; i < TICK * 2; i++) step("R3 prescaler ignored");

    // R10: raise and ack in the same cycle, request already pending.
    irqAck = 1'b1; flagClr = 1'b1;
    step("R10 ack");
    loadEn = 1'b1; loadVal = CW'(CMAX);
    step("R8 load max");
    evtLine = 1'b1;
    step("R5 event wrap raise");
    evtLine = 1'b0; flagClr = 1'b1;
    step("R9 clear with req pending");
    loadEn = 1'b1; loadVal = CW'(CMAX);
    step("R8 load max again");
    evtLine = 1'b1; irqAck = 1'b1;
    step("R10 raise beats ack");
    evtLine = 1'b0; irqAck = 1'b1; flagClr = 1'b1;
    step("R10 ack clears");

    // R9: clear strobe on the wrapping edge, flag ends at 1.
    loadEn = 1'b1; loadVal = CW'(CMAX);
    step("R8 load");
    evtLine = 1'b1; flagClr = 1'b1;
    step("R9 set wins over clear");
    evtLine = 1'b0; flagSet = 1'b1;
    step("R9 set strobe");
    irqAck = 1'b1;
    step("R10 ack keeps flag");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule